// File: doc/BRIEF.md
# DMA channel register bank

This block holds the programming registers of a multi-channel DMA controller. Each channel has its own 4 KiB address window. Inside that window are a 32-bit control word, a pending configuration word, and three 64-bit pending registers: byte count, destination address and source address. The window also holds the executing copies of the configuration and of those three registers. Software programs the pending set and reads everything back over a single-cycle register bus that carries 32-bit or 64-bit accesses.

Each 64-bit register can be reached in two ways. A single quadword access at its base offset covers the whole register. Two 32-bit accesses, one at the base and one at base+4, reach the lower and upper halves, and each half write merges into the stored value. The executing registers are read-only from the bus. The transfer engine loads them through a dedicated port per channel. The pending registers and the control word are driven continuously to the engine.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, every register of every channel reads zero, the engine-facing outputs are zero, and `bus_err` and `bus_rdata` are zero.
- R2: Address bits 11:0 are the in-channel offset and the bits above select the channel. A write changes only the addressed channel. The control word (offset 0x000) and the pending configuration (offset 0x004) are 32-bit read/write and appear on the engine outputs.
- R3: A 32-bit write (`bus_size`=4) at a 64-bit register's base replaces only bits 31:0, and one at base+4 replaces only bits 63:32. The pending byte count, destination and source have their bases at 0x008, 0x010 and 0x018.
- R4: A 32-bit read at a 64-bit register's base returns bits 31:0, and one at base+4 returns bits 63:32. Bits 63:32 of `bus_rdata` are zero on every 32-bit read.
- R5: A 64-bit access (`bus_size`=8) at a 64-bit register's base reads or writes the whole register.
- R6: A 64-bit access at any offset other than the six 64-bit bases reads zero and changes nothing.
- R7: The executing registers ignore bus writes of either size. They are the configuration at 0x104 and the byte count, destination and source with bases 0x108, 0x110 and 0x118. When `eng_load[c]` is high, all four executing registers of channel c load from the engine inputs at that edge.
- R8: An access to a channel number at or above NCH reads zero, ignores writes and raises no error.
- R9: An access whose `bus_size` is neither 4 nor 8 reads zero, ignores writes and raises no error.
- R10: A 32-bit access to a valid channel at an offset that matches no register reads zero. It pulses `bus_err` for exactly the cycle after the access, and no other access raises `bus_err`.
- R11: `bus_rdata` is registered. It carries the read result in the cycle after a read access and is zero after a write or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address: channel above bit 11, offset in 11:0 |
| bus_size | input | 4 | Access size in bytes (4 or 8 legal) |
| bus_wdata | input | 64 | Write data (32-bit writes use bits 31:0) |
| bus_rdata | output | 64 | Registered read data |
| bus_err | output | 1 | One-cycle unmatched-offset flag |
| eng_load | input | NCH | Per-channel load strobe for the executing registers |
| eng_cfg | input | NCH*32 | Executing configuration to load, per channel |
| eng_bytes | input | NCH*64 | Executing byte count to load |
| eng_dst | input | NCH*64 | Executing destination to load |
| eng_src | input | NCH*64 | Executing source to load |
| ctrl_o | output | NCH*32 | Control word per channel |
| ncfg_o | output | NCH*32 | Pending configuration per channel |
| nbytes_o | output | NCH*64 | Pending byte count per channel |
| ndst_o | output | NCH*64 | Pending destination per channel |
| nsrc_o | output | NCH*64 | Pending source per channel |

## Verification
Read data and the error flag are produced one clock edge after the access. The bench holds each access for one cycle from a falling edge and samples `bus_rdata` and `bus_err` at the following falling edge, which is one rising edge later. A register write takes effect at the edge that accepts it. Every write is therefore followed by a read of the same address and size in a later access, so each read sees the updated value. Engine loads are applied from a falling edge for one cycle and are read back over the bus afterwards. The engine-facing outputs are compared only after the bus has gone idle.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int NCH    = 2,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_size,
  input  logic [63:0]       bus_wdata,
  output logic [63:0]       bus_rdata,
  output logic              bus_err,
  input  logic [NCH-1:0]    eng_load,
  input  logic [NCH*32-1:0] eng_cfg,
  input  logic [NCH*64-1:0] eng_bytes,
  input  logic [NCH*64-1:0] eng_dst,
  input  logic [NCH*64-1:0] eng_src,
  output logic [NCH*32-1:0] ctrl_o,
  output logic [NCH*32-1:0] ncfg_o,
  output logic [NCH*64-1:0] nbytes_o,
  output logic [NCH*64-1:0] ndst_o,
  output logic [NCH*64-1:0] nsrc_o
);
  localparam int CHW = ADDR_W - 12;

  logic [31:0] ctrl [NCH];
  logic [31:0] ncfg [NCH];
  logic [31:0] xcfg [NCH];
  logic [63:0] nb [NCH], nd [NCH], ns [NCH];
  logic [63:0] xb [NCH], xd [NCH], xs [NCH];

  wire [11:0]    off  = bus_addr[11:0];
  wire [CHW-1:0] chan = bus_addr[ADDR_W-1:12];
  wire           sz32 = (bus_size == 4'd4);
  wire           sz64 = (bus_size == 4'd8);
  wire           ch_ok = ({{(32-CHW){1'b0}}, chan} < NCH);

  logic known32;
  always_comb begin
    case (off)
      12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h014, 12'h018, 12'h01C,
      12'h104, 12'h108, 12'h10C, 12'h110, 12'h114, 12'h118, 12'h11C: known32 = 1'b1;
      default: known32 = 1'b0;
    endcase
  end

  logic [63:0] rd_val;
  always_comb begin
    rd_val = '0;
    for (int c = 0; c < NCH; c++) begin
      if (chan == CHW'(c)) begin
        if (sz32) begin
          case (off)
            12'h000: rd_val = {32'd0, ctrl[c]};
            12'h004: rd_val = {32'd0, ncfg[c]};
            12'h008: rd_val = {32'd0, nb[c][31:0]};
            12'h00C: rd_val = {32'd0, nb[c][63:32]};
            12'h010: rd_val = {32'd0, nd[c][31:0]};
            12'h014: rd_val = {32'd0, nd[c][63:32]};
            12'h018: rd_val = {32'd0, ns[c][31:0]};
            12'h01C: rd_val = {32'd0, ns[c][63:32]};
            12'h104: rd_val = {32'd0, xcfg[c]};
            12'h108: rd_val = {32'd0, xb[c][31:0]};
            12'h10C: rd_val = {32'd0, xb[c][63:32]};
            12'h110: rd_val = {32'd0, xd[c][31:0]};
            12'h114: rd_val = {32'd0, xd[c][63:32]};
            12'h118: rd_val = {32'd0, xs[c][31:0]};
            12'h11C: rd_val = {32'd0, xs[c][63:32]};
            default: rd_val = '0;
          endcase
        end else if (sz64) begin
          case (off)
            12'h008: rd_val = nb[c];
            12'h010: rd_val = nd[c];
            12'h018: rd_val = ns[c];
            12'h108: rd_val = xb[c];
            12'h110: rd_val = xd[c];
            12'h118: rd_val = xs[c];
            default: rd_val = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= (bus_en && !bus_we) ? rd_val : '0;
      bus_err   <= bus_en && sz32 && ch_ok && !known32;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        ctrl[c] <= '0; ncfg[c] <= '0; xcfg[c] <= '0;
        nb[c] <= '0; nd[c] <= '0; ns[c] <= '0;
        xb[c] <= '0; xd[c] <= '0; xs[c] <= '0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (eng_load[c]) begin
          xcfg[c] <= eng_cfg[c*32 +: 32];
          xb[c]   <= eng_bytes[c*64 +: 64];
          xd[c]   <= eng_dst[c*64 +: 64];
          xs[c]   <= eng_src[c*64 +: 64];
        end
        if (bus_en && bus_we && chan == CHW'(c)) begin
          if (sz32) begin
            case (off)
              12'h000: ctrl[c]        <= bus_wdata[31:0];
              12'h004: ncfg[c]        <= bus_wdata[31:0];
              12'h008: nb[c][31:0]    <= bus_wdata[31:0];
              12'h00C: nb[c][63:32]   <= bus_wdata[31:0];
              12'h010: nd[c][31:0]    <= bus_wdata[31:0];
              12'h014: nd[c][63:32]   <= bus_wdata[31:0];
              12'h018: ns[c][31:0]    <= bus_wdata[31:0];
              12'h01C: ns[c][63:32]   <= bus_wdata[31:0];
              default: ;
            endcase
          end else if (sz64) begin
            case (off)
              12'h008: nb[c] <= bus_wdata;
              12'h010: nd[c] <= bus_wdata;
              12'h018: ns[c] <= bus_wdata;
              default: ;
            endcase
          end
        end
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign ctrl_o[g*32 +: 32]   = ctrl[g];
    assign ncfg_o[g*32 +: 32]   = ncfg[g];
    assign nbytes_o[g*64 +: 64] = nb[g];
    assign ndst_o[g*64 +: 64]   = nd[g];
    assign nsrc_o[g*64 +: 64]   = ns[g];

    AST_EXEC_HOLD: assert property (@(posedge clk) disable iff (rst)
      !eng_load[g] |=> ($stable(xb[g]) && $stable(xd[g]) && $stable(xs[g]) && $stable(xcfg[g]))); // R7
  end

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !(bus_en && !bus_we) |=> (bus_rdata == '0)); // R11
  AST_RD32_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !bus_we && sz32) |=> (bus_rdata[63:32] == 32'd0)); // R4
  AST_BADCH_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !ch_ok) |=> ($stable(ctrl_o) && $stable(ncfg_o) && $stable(nbytes_o)
                            && $stable(ndst_o) && $stable(nsrc_o) && !bus_err)); // R8
  AST_BADSIZE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !sz32 && !sz64) |=> (bus_rdata == '0 && !bus_err && $stable(nbytes_o)
                                    && $stable(ndst_o) && $stable(nsrc_o))); // R9
  AST_ERR_ONLY_32: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past(bus_en && sz32)); // R10
endmodule

// File: tb/test_dma_chan_regs.sv
module test_dma_chan_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int ADDR_W = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_en = 0, bus_we = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [3:0] bus_size = '0;
  logic [63:0] bus_wdata = '0, bus_rdata;
  logic bus_err;
  logic [NCH-1:0] eng_load = '0;
  logic [NCH*32-1:0] eng_cfg = '0;
  logic [NCH*64-1:0] eng_bytes = '0, eng_dst = '0, eng_src = '0;
  logic [NCH*32-1:0] ctrl_o, ncfg_o;
  logic [NCH*64-1:0] nbytes_o, ndst_o, nsrc_o;

  dma_chan_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) i_dma_chan_regs (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .eng_load(eng_load), .eng_cfg(eng_cfg), .eng_bytes(eng_bytes), .eng_dst(eng_dst),
    .eng_src(eng_src), .ctrl_o(ctrl_o), .ncfg_o(ncfg_o), .nbytes_o(nbytes_o),
    .ndst_o(ndst_o), .nsrc_o(nsrc_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  // model: 0 ctrl, 1 ncfg, 2 nbytes, 3 ndst, 4 nsrc, 5 xcfg, 6 xbytes, 7 xdst, 8 xsrc
  logic [63:0] m [NCH][9];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit known32(input int off);
    return (off <= 'h1C) || (off >= 'h104 && off <= 'h11C);
  endfunction

  function automatic logic [63:0] exp_read(input int ch, input int off, input int sz);
    if (ch >= NCH) return '0;
    if (sz == 4) begin
      case (off)
        'h000: return m[ch][0];
        'h004: return m[ch][1];
        'h104: return m[ch][5];
        'h008, 'h010, 'h018: return {32'd0, m[ch][2 + (off-8)/8][31:0]};
        'h00C, 'h014, 'h01C: return {32'd0, m[ch][2 + (off-12)/8][63:32]};
        'h108, 'h110, 'h118: return {32'd0, m[ch][6 + (off-'h108)/8][31:0]};
        'h10C, 'h114, 'h11C: return {32'd0, m[ch][6 + (off-'h10C)/8][63:32]};
        default: return '0;
      endcase
    end
    if (sz == 8) begin
      case (off)
        'h008, 'h010, 'h018: return m[ch][2 + (off-8)/8];
        'h108, 'h110, 'h118: return m[ch][6 + (off-'h108)/8];
        default: return '0;
      endcase
    end
    return '0;
  endfunction

  task automatic model_write(input int ch, input int off, input int sz, input logic [63:0] d);
    if (ch >= NCH) return;
    if (sz == 4) begin
      case (off)
        'h000: m[ch][0] = {32'd0, d[31:0]};
        'h004: m[ch][1] = {32'd0, d[31:0]};
        'h008, 'h010, 'h018: m[ch][2 + (off-8)/8][31:0] = d[31:0];
        'h00C, 'h014, 'h01C: m[ch][2 + (off-12)/8][63:32] = d[31:0];
        default: ;
      endcase
    end else if (sz == 8) begin
      if (off == 'h008 || off == 'h010 || off == 'h018) m[ch][2 + (off-8)/8] = d;
    end
  endtask

  function automatic string tag(input int ch, input int off, input int sz, input bit we);
    if (ch >= NCH) return "R8";
    if (sz != 4 && sz != 8) return "R9";
    if (sz == 8) begin
      if (off == 'h008 || off == 'h010 || off == 'h018) return "R5";
      if (off == 'h108 || off == 'h110 || off == 'h118) return we ? "R7" : "R5";
      return "R6";
    end
    if (!known32(off)) return "R10";
    if (off >= 'h104) return we ? "R7" : "R4";
    if (off >= 'h008) return we ? "R3" : "R4";
    return "R2";
  endfunction

  task automatic access(input int ch, input int off, input int sz, input bit we,
                        input logic [63:0] d, output logic [63:0] rd, output logic er);
    @(negedge clk);
    bus_en = 1; bus_we = we; bus_addr = {ch[3:0], off[11:0]}; bus_size = sz[3:0]; bus_wdata = d;
    @(negedge clk);
    rd = bus_rdata; er = bus_err; bus_en = 0; bus_we = 0;
  endtask

  task automatic eng_push(input int ch, input logic [31:0] c, input logic [63:0] b,
                          input logic [63:0] dd, input logic [63:0] s);
    @(negedge clk);
    eng_load[ch] = 1'b1;
    eng_cfg[ch*32 +: 32] = c; eng_bytes[ch*64 +: 64] = b;
    eng_dst[ch*64 +: 64] = dd; eng_src[ch*64 +: 64] = s;
    @(negedge clk);
    eng_load = '0;
    m[ch][5] = {32'd0, c}; m[ch][6] = b; m[ch][7] = dd; m[ch][8] = s;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd;
    logic er;
    int n = 0;
    int sizes [4] = '{4, 8, 2, 1};
    for (int c = 0; c < NCH; c++) for (int r = 0; r < 9; r++) m[c][r] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1", bus_rdata, 64'd0, "rdata after reset");
    check("R1", {63'd0, bus_err}, 64'd0, "err after reset");
    check("R1", {ctrl_o, ncfg_o}, '0, "ctrl/cfg outputs after reset");
    check("R1", nbytes_o | ndst_o | nsrc_o, '0, "pending outputs after reset");
    for (int c = 0; c < NCH; c++)
      for (int off = 0; off <= 'h11C; off += 4)
        if (known32(off)) begin
          access(c, off, 4, 0, '0, rd, er);
          check("R1", rd, 64'd0, $sformatf("reset read ch%0d off %h", c, off));
        end

    for (int c = 0; c < NCH; c++)
      eng_push(c, 32'hC0F0_0000 + c, 64'hB000_0001_0000_0010 * (c+1),
               64'hD000_0002_0000_0020 * (c+1), 64'h5000_0003_0000_0030 * (c+1));

    for (int ch = 0; ch < 4; ch++)
      for (int off = 0; off <= 'h124; off += 4)
        for (int si = 0; si < 4; si++) begin
          int sz = sizes[si];
          logic [63:0] d;
          bit xe;
          n++;
          d = 64'h9E37_79B9_7F4A_7C15 * n;
          xe = (sz == 4) && (ch < NCH) && !known32(off);
          access(ch, off, sz, 1, d, rd, er);
          check("R11", rd, 64'd0, $sformatf("rdata after write ch%0d off %h sz%0d", ch, off, sz));
          check(tag(ch, off, sz, 1), {63'd0, er}, {63'd0, xe}, $sformatf("err on write ch%0d off %h sz%0d", ch, off, sz));
          model_write(ch, off, sz, d);
          access(ch, off, sz, 0, '0, rd, er);
          check(tag(ch, off, sz, 1), rd, exp_read(ch, off, sz), $sformatf("readback ch%0d off %h sz%0d", ch, off, sz));
          check(tag(ch, off, sz, 0), {63'd0, er}, {63'd0, xe}, $sformatf("err on read ch%0d off %h sz%0d", ch, off, sz));
        end

    for (int c = 0; c < NCH; c++)
      for (int off = 0; off <= 'h11C; off += 4)
        if (known32(off)) begin
          access(c, off, 4, 0, '0, rd, er);
          check(tag(c, off, 4, 0), rd, exp_read(c, off, 4), $sformatf("final read ch%0d off %h", c, off));
        end

    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      check("R2", {32'd0, ctrl_o[c*32 +: 32]}, m[c][0], $sformatf("ctrl_o ch%0d", c));
      check("R2", {32'd0, ncfg_o[c*32 +: 32]}, m[c][1], $sformatf("ncfg_o ch%0d", c));
      check("R2", nbytes_o[c*64 +: 64], m[c][2], $sformatf("nbytes_o ch%0d", c));
      check("R2", ndst_o[c*64 +: 64], m[c][3], $sformatf("ndst_o ch%0d", c));
      check("R2", nsrc_o[c*64 +: 64], m[c][4], $sformatf("nsrc_o ch%0d", c));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule